// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This block takes received frames from a byte stream and writes each one into the buffer of the next receive descriptor that software has handed to it. Descriptors form a ring in memory. Each descriptor is three 32-bit words: a flag word, a size/length word and a buffer pointer. When a frame has been stored, the engine writes back the stored length, marks any error and returns the descriptor to software by clearing its active flag. It then moves on to the next descriptor.

Software builds the ring and marks descriptors active. It presents the ring start on `ring_base` and pulses `rx_go`. When the engine finds a descriptor that is not active, it stops and drops `rx_run`, and it waits for the next `rx_go`. Frames arrive on a valid/ready byte stream. A byte transfers on a rising edge where `s_valid` and `s_ready` are both high, and the sender must hold its data, `s_last` and `s_err` steady until that happens. `s_ready` is low whenever the engine is stopped, fetching a descriptor, writing a data word to memory, or writing back status. The memory port uses a request/acknowledge pair. Each access is one 32-bit word with per-byte enables.

Top module: `rx_desc_dma`

## Requirements
- R1: A descriptor at byte address A occupies A (flags), A+4 (buffer size in bits 31:16, stored length in bits 15:0) and A+8 (buffer byte address, 32-byte aligned). In the flag word, bit 31 is active, bit 30 is end-of-ring and bit 27 is frame-error.
- R2: When the engine reads a flag word whose active bit is 0, it stops: `rx_run` goes to 0, `s_ready` stays 0 and no memory write is made to that descriptor.
- R3: Frame byte j is stored at buffer address + j, packed little-endian (byte j in bits 8*(j mod 4) and up). A partial final word is written with only the enables of its stored bytes, so the other bytes of that word are left unchanged.
- R4: On completion, the engine writes word A+4 as {buffer size, stored length}. It then writes word A with the active bit cleared and every other bit kept from the value it read.
- R5: If `s_err` is high on any accepted byte of a frame, that frame's frame-error bit is set to 1.
- R6: Bytes beyond the buffer size are discarded. The stored length is then the buffer size and the frame-error bit is set.
- R7: After a descriptor whose end-of-ring bit is 1, the next descriptor is at `ring_base`. Otherwise the next descriptor is 12 bytes further on.
- R8: A pulse on `rx_go` while stopped restarts the engine. After reset, the first start begins at `ring_base`. Later starts resume at the descriptor where the engine stopped.
- R9: `mem_req` and `mem_addr` are held until `mem_ack`. Data stored under a slow, stalling memory is identical to data stored under a fast one.
- R10: After reset, `rx_run`, `s_ready` and `mem_req` are 0. `rx_run` reads 1 from the cycle after `rx_go` until the engine stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | 32 | Byte address of the first descriptor |
| rx_go | input | 1 | Pulse to enable reception |
| rx_run | output | 1 | Enable state; 0 once stopped |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Engine accepts a byte |
| s_data | input | 8 | Stream byte |
| s_last | input | 1 | Final byte of frame |
| s_err | input | 1 | Byte received with error |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Byte enables |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The frames vary in length: one byte, exact multiples of four, odd tails, exactly the buffer size, and longer than the buffer. Comparing each whole buffer against a fill pattern distinguishes correct byte-enable masking from over-writing, and distinguishes length capping from counting the dropped bytes. Frames with an error marked on a middle byte are mixed with clean ones, which separates the error source from the truncation source of the frame-error bit. Descriptors are armed one at a time, so every frame also exercises the stop and resume behaviour and wraps the ring twice. Some frames run against a memory that acknowledges only every other cycle, which shows that stalls leave no trace in the stored data.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int ACT_BIT  = 31;
  localparam int RING_END = 30;
  localparam int FERR_BIT = 27;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_RECV, ST_WDAT, ST_WLEN, ST_WFLG
  } rxd_state_e;
endpackage

// File: rtl/rxd_packer.sv
module rxd_packer #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          take,
  input  logic [7:0]    din,
  input  logic          flush,
  input  logic [LW-1:0] buf_size,
  output logic [31:0]   word,
  output logic [3:0]    be,
  output logic [LW-1:0] count,
  output logic          dropped
);
  logic [1:0] lane;
  assign lane = count[1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      word    <= '0;
      be      <= '0;
      count   <= '0;
      dropped <= 1'b0;
    end else begin
      if (flush) be <= '0;
      if (take) begin
        if (count < buf_size) begin
          word[8*lane +: 8] <= din;
          be[lane]          <= 1'b1;
          count             <= count + 1'b1;
        end else begin
          dropped <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/rxd_ctrl.sv
module rxd_ctrl
  import rxd_pkg::*;
#(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic          rx_go,
  output logic          rx_run,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic          s_last,
  input  logic          s_err,
  output logic          take,
  output logic          clr,
  output logic          flush,
  output logic [LW-1:0] buf_size,
  input  logic [31:0]   pk_word,
  input  logic [3:0]    pk_be,
  input  logic [LW-1:0] pk_count,
  input  logic          pk_dropped,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata
);
  localparam int DESC_BYTES = 12;

  rxd_state_e    state;
  logic [AW-1:0] cur, baddr;
  logic [31:0]   flags, wflag;
  logic          started, fin, err_seen;
  logic [LW-1:0] off;

  assign rx_run  = (state != ST_IDLE);
  assign s_ready = (state == ST_RECV) && (pk_be != 4'hF) && !fin;
  assign take    = s_valid && s_ready;
  assign clr     = (state == ST_RD2) && mem_ack;
  assign flush   = (state == ST_WDAT) && mem_ack;
  assign off     = (pk_count - 1'b1) & ~LW'(3);

  always_comb begin
    wflag           = flags;
    wflag[ACT_BIT]  = 1'b0;
    if (err_seen || pk_dropped) wflag[FERR_BIT] = 1'b1;
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur;
    mem_wdata = '0;
    mem_be    = 4'hF;
    case (state)
      ST_RD0: mem_req = 1'b1;
      ST_RD1: begin mem_req = 1'b1; mem_addr = cur + AW'(4); end
      ST_RD2: begin mem_req = 1'b1; mem_addr = cur + AW'(8); end
      ST_WDAT: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = baddr + {{(AW-LW){1'b0}}, off};
        mem_wdata = pk_word;
        mem_be    = pk_be;
      end
      ST_WLEN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur + AW'(4);
        mem_wdata = {16'(buf_size), 16'(pk_count)};
      end
      ST_WFLG: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = wflag;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cur      <= '0;
      baddr    <= '0;
      flags    <= '0;
      buf_size <= '0;
      started  <= 1'b0;
      fin      <= 1'b0;
      err_seen <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (rx_go) begin
          state   <= ST_RD0;
          started <= 1'b1;
          if (!started) cur <= ring_base;
        end
        ST_RD0: if (mem_ack) begin
          flags <= mem_rdata;
          state <= mem_rdata[ACT_BIT] ? ST_RD1 : ST_IDLE;
        end
        ST_RD1: if (mem_ack) begin
          buf_size <= LW'(mem_rdata[31:16]);
          state    <= ST_RD2;
        end
        ST_RD2: if (mem_ack) begin
          baddr    <= mem_rdata;
          fin      <= 1'b0;
          err_seen <= 1'b0;
          state    <= ST_RECV;
        end
        ST_RECV: begin
          if (take) begin
            if (s_err)  err_seen <= 1'b1;
            if (s_last) fin      <= 1'b1;
          end
          if (pk_be == 4'hF || (fin && pk_be != 4'h0)) state <= ST_WDAT;
          else if (fin)                                 state <= ST_WLEN;
        end
        ST_WDAT: if (mem_ack) state <= ST_RECV;
        ST_WLEN: if (mem_ack) state <= ST_WFLG;
        ST_WFLG: if (mem_ack) begin
          cur   <= flags[RING_END] ? ring_base : cur + AW'(DESC_BYTES);
          state <= ST_RD0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ring_base,
  input  logic          rx_go,
  output logic          rx_run,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [7:0]    s_data,
  input  logic          s_last,
  input  logic          s_err,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  output logic [3:0]    mem_be,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata
);
  logic          take, clr, flush, pk_dropped;
  logic [LW-1:0] buf_size, pk_count;
  logic [31:0]   pk_word;
  logic [3:0]    pk_be;

  rxd_ctrl #(.AW(AW), .LW(LW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .rx_go(rx_go),
    .rx_run(rx_run), .s_valid(s_valid), .s_ready(s_ready),
    .s_last(s_last), .s_err(s_err), .take(take), .clr(clr),
    .flush(flush), .buf_size(buf_size), .pk_word(pk_word),
    .pk_be(pk_be), .pk_count(pk_count), .pk_dropped(pk_dropped),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata)
  );

  rxd_packer #(.LW(LW)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(clr), .take(take), .din(s_data),
    .flush(flush), .buf_size(buf_size), .word(pk_word), .be(pk_be),
    .count(pk_count), .dropped(pk_dropped)
  );
endmodule

// File: rtl/rx_desc_dma_chk.sv
module rx_desc_dma_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_run,
  input logic          s_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [3:0]    mem_be
);
  // R2 / R10: no stream acceptance while stopped
  assert_ready_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_run |-> !s_ready);

  // R2: a stopped engine makes no memory access
  assert_no_access_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_run |-> !mem_req);

  // R9: request and address held through a stall
  assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R1: accesses are whole-word aligned
  assert_word_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));

  // R3: every write enables at least one byte
  assert_write_enables_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_be != 4'h0));

  // R9: stream is held off while memory traffic is outstanding
  assert_ready_vs_mem_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !s_ready);
endmodule

bind rx_desc_dma rx_desc_dma_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_run(rx_run), .s_ready(s_ready),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_be(mem_be)
);

// File: tb/sim_rx_desc_dma.sv
module sim_rx_desc_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ring_base = 32'h0;
  logic        rx_go = 1'b0;
  logic        rx_run, s_ready;
  logic        s_valid = 1'b0, s_last = 1'b0, s_err = 1'b0;
  logic [7:0]  s_data = 8'h00;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        slow = 1'b0, tog = 1'b0;
  logic [31:0] mem [64];
  int          checks = 0, fails = 0;

  localparam logic [31:0] ACT = 32'h8000_0000, RING_END = 32'h4000_0000;
  localparam logic [31:0] FERR = 32'h0800_0000, MARK = 32'h0000_0055;
  localparam logic [31:0] FILL = 32'hA5A5_A5A5;
  // [7:0] frame length, [15:8] buffer size, [16] error mid-frame, [17] slow memory
  localparam int NV = 7;
  localparam logic [31:0] VEC [NV] = '{
    32'h0000_2005, 32'h0001_2008, 32'h0002_1001, 32'h0000_080C,
    32'h0003_0707, 32'h0000_181E, 32'h0000_2004 };

  always #4 clk = ~clk;

  rx_desc_dma u0 (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .rx_go(rx_go),
    .rx_run(rx_run), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_last(s_last), .s_err(s_err), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_be(mem_be),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  assign mem_ack   = mem_req && (!slow || tog);
  assign mem_rdata = mem[mem_addr[7:2]];

  always @(posedge clk) begin
    tog <= ~tog;
    if (mem_req && mem_we && mem_ack)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[7:2]][8*b +: 8] <= mem_wdata[8*b +: 8];
  end

  task automatic check(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic pulse_go();
    @(negedge clk); rx_go = 1'b1;
    @(negedge clk); rx_go = 1'b0;
  endtask

  task automatic send_frame(input int n, input int fid, input bit err);
    for (int j = 0; j < n; j++) begin
      s_valid = 1'b1;
      s_data  = 8'((fid * 37 + j + 3) & 8'hFF);
      s_last  = (j == n - 1);
      s_err   = err && (j == n / 2);
      while (!s_ready) @(negedge clk);
      @(negedge clk);
    end
    s_valid = 1'b0; s_last = 1'b0; s_err = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int w = 0; w < 64; w++) mem[w] = 32'h0;
    for (int d = 0; d < 3; d++) begin
      mem[3*d]     = (d == 2) ? (RING_END | MARK) : MARK;
      mem[3*d + 2] = 32'h40 + 32'(d) * 32'h20;
    end
    repeat (3) @(negedge clk);
    // R10: reset state
    check(!rx_run && !s_ready && !mem_req, "R10 reset outputs idle", {29'h0, rx_run, s_ready, mem_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      int idx, n, sz, cap, bw;
      bit er, fe, data_ok;
      logic [31:0] bad;
      idx = i % 3;
      n   = int'(VEC[i][7:0]);
      sz  = int'(VEC[i][15:8]);
      er  = VEC[i][16];
      slow = VEC[i][17];
      cap = (n < sz) ? n : sz;
      fe  = er || (n > sz);
      bw  = 16 + idx * 8;
      for (int w = 0; w < 8; w++) mem[bw + w] = FILL;
      mem[3*idx + 1] = {16'(sz), 16'h0};
      mem[3*idx]     = ACT | MARK | ((idx == 2) ? RING_END : 32'h0);
      pulse_go();
      // R8 / R10: enabled after the pulse, resumes at the next descriptor
      check(rx_run == 1'b1, "R10 rx_run set after go", {31'h0, rx_run}, 32'h1);
      send_frame(n, i, er);
      for (int t = 0; t < 2000 && mem[3*idx][31]; t++) @(negedge clk);
      repeat (10) @(negedge clk);
      // R4 / R6: length word
      check(mem[3*idx + 1] == {16'(sz), 16'(cap)}, "R4 R6 size/length word",
            mem[3*idx + 1], {16'(sz), 16'(cap)});
      // R4 / R5 / R6 / R7 / R8: flag word of the expected descriptor
      check(mem[3*idx] == (MARK | ((idx == 2) ? RING_END : 32'h0) | (fe ? FERR : 32'h0)),
            "R5 R6 R7 R8 flag word writeback", mem[3*idx],
            MARK | ((idx == 2) ? RING_END : 32'h0) | (fe ? FERR : 32'h0));
      // R3 / R9: buffer contents and untouched bytes
      data_ok = 1'b1; bad = 32'h0;
      for (int j = 0; j < 32; j++) begin
        logic [7:0] got, want;
        got  = mem[bw + j/4][8*(j%4) +: 8];
        want = (j < cap) ? 8'((i * 37 + j + 3) & 8'hFF) : 8'hA5;
        if (got != want && data_ok) begin data_ok = 1'b0; bad = {8'(j), 8'h0, got, want}; end
      end
      check(data_ok, "R3 R9 buffer bytes (pos,_,got,want)", bad, 32'h0);
      // R2: stopped on the inactive next descriptor
      check(!rx_run && !s_ready, "R2 stopped on inactive descriptor", {30'h0, rx_run, s_ready}, 32'h0);
    end
    slow = 1'b0;

    // R2: inactive descriptor -> stop, no write, stream refused
    begin
      logic [31:0] w0;
      w0 = mem[3];
      pulse_go();
      repeat (6) @(negedge clk);
      check(!rx_run, "R2 go on inactive descriptor stops", {31'h0, rx_run}, 32'h0);
      check(mem[3] == w0, "R2 inactive descriptor untouched", mem[3], w0);
      s_valid = 1'b1; s_data = 8'h11; s_last = 1'b1;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        check(!s_ready, "R2 s_ready low while stopped", {31'h0, s_ready}, 32'h0);
      end
      s_valid = 1'b0; s_last = 1'b0;
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule